// File: doc/BRIEF.md
# Sensor Register Bank with Shadow Readback

This block sits between a byte-wide host bus and an image-sensor controller. It holds a 1 KB byte RAM divided into eight banks of 128 bytes, a bank-select register, and a control register whose bits drive the sensor's standby and column-noise correction, a calibration request and a serial trigger. The host picks data or register space with `bus_reg`, and within either space picks a 7-bit offset.

Data accesses reach the bank named by the bank register. Register accesses always land in bank 6 as well, so a write-only register can be read back later from that copy. Writes to sensor registers are sent to the sensor only while bank 0 is selected. A calibration request is held until the frame timing reports an inter-frame gap. A change of the trigger bit produces a single pulse.

Top module: `sensor_reg_bank`

## Requirements
- R1: A data-space access (`bus_reg`=0) addresses RAM byte {bank, `bus_addr`}, giving 8 banks of 128 bytes each. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R2: Every register-space write (`bus_reg`=1) is stored at bank 6, offset `bus_addr`, whatever bank is selected. That copy can be read from data space with bank 6 selected.
- R3: A register-space read returns the bank-6 shadow byte at that offset. The one exception is the bank register.
- R4: The bank register is at register offset 0x71. Write bits [2:0] select the bank and write bits [7:3] are ignored. A read returns the live bank in [2:0] and zeros in [7:3].
- R5: A register write to any offset other than 0x70 or 0x71 while bank 0 is selected raises `sensor_wr` for one cycle after the write, with the offset and data. With any other bank selected, `sensor_wr` stays low.
- R6: The control register is at offset 0x70. Bit 0 drives `standby` and bit 1 drives `dark_offset`. Both update after a control write and hold until the next control write.
- R7: A control write with bit 2 = 1 sets a pending calibration. A control write with bit 2 = 0 neither sets nor clears it.
- R8: `cal_start` is high exactly in the cycles where a calibration is pending and `frame_gap` is high. The pending flag clears at the end of that cycle, so one request yields one pulse.
- R9: Several requests made while a calibration is already pending merge into a single `cal_start`.
- R10: A request written in the same cycle that `cal_start` fires stays pending and is issued at a later gap.
- R11: Bit 3 of the control register is the trigger. Writing a value that differs from the stored one gives a one-cycle `trig_pulse` in the cycle after the write. Writing the same value gives no pulse.
- R12: After reset, `standby`, `dark_offset`, `sensor_wr`, `trig_pulse` and `cal_start` are low, the bank is 0, and no calibration is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_reg | input | 1 | 1 selects register space, 0 selects data space |
| bus_addr | input | 7 | Offset inside the bank or register space |
| bus_wdata | input | 8 | Write data |
| frame_gap | input | 1 | High while the sensor is between frames |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| sensor_wr | output | 1 | Write strobe toward the sensor registers |
| sensor_addr | output | 7 | Sensor register offset |
| sensor_wdata | output | 8 | Sensor register data |
| standby | output | 1 | Low-power standby request |
| dark_offset | output | 1 | Column-noise correction enable |
| trig_pulse | output | 1 | One-cycle pulse on a trigger toggle |
| cal_start | output | 1 | Calibration issue strobe |

## Verification
Two events can meet in one cycle: the calibration issue (pending flag and `frame_gap` both high) and a new host request that writes 1 to the calibrate bit. The bench raises `frame_gap` and drives the control write in the same cycle. It then expects `cal_start` high in that cycle, low once the gap is removed, and high again when the next gap opens, because the new request must not be lost. The bench also checks that a second toggle written during an active trigger pulse extends the pulse correctly.

// File: rtl/sensor_reg_bank.sv
module sensor_reg_bank #(
  parameter int DATA_W      = 8,
  parameter int OFFS_W      = 7,
  parameter int BANK_W      = 3,
  parameter int SHADOW_BANK = 6,
  parameter int SENSOR_BANK = 0,
  parameter logic [OFFS_W-1:0] CTRL_OFFS = 'h70,
  parameter logic [OFFS_W-1:0] BANK_OFFS = 'h71,
  parameter int STBY_BIT    = 0,
  parameter int DARK_BIT    = 1,
  parameter int CAL_BIT     = 2,
  parameter int TRIG_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_reg,
  input  logic [OFFS_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              frame_gap,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sensor_wr,
  output logic [OFFS_W-1:0] sensor_addr,
  output logic [DATA_W-1:0] sensor_wdata,
  output logic              standby,
  output logic              dark_offset,
  output logic              trig_pulse,
  output logic              cal_start
);
  localparam int RAM_AW = BANK_W + OFFS_W;
  localparam int DEPTH  = 1 << RAM_AW;
  localparam logic [BANK_W-1:0] SHADOW_SEL = BANK_W'(SHADOW_BANK);
  localparam logic [BANK_W-1:0] SENSOR_SEL = BANK_W'(SENSOR_BANK);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BANK_W-1:0] bank_q;
  logic              cal_pend;
  logic              trig_q, trig_seen;

  wire is_ctrl    = bus_addr == CTRL_OFFS;
  wire is_bank    = bus_addr == BANK_OFFS;
  wire reg_wr     = bus_wr & bus_reg;
  wire ctrl_wr    = reg_wr & is_ctrl;
  wire bank_wr    = reg_wr & is_bank;
  wire cal_req    = ctrl_wr & bus_wdata[CAL_BIT];
  wire sens_req   = reg_wr & ~is_ctrl & ~is_bank & (bank_q == SENSOR_SEL);

  wire [BANK_W-1:0] acc_bank = bus_reg ? SHADOW_SEL : bank_q;
  wire [RAM_AW-1:0] ram_addr = {acc_bank, bus_addr};

  always_ff @(posedge clk)
    if (bus_wr) mem[ram_addr] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= (bus_reg && is_bank) ? DATA_W'(bank_q) : mem[ram_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bank_q <= '0;
    else if (bank_wr) bank_q <= bus_wdata[BANK_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sensor_wr    <= 1'b0;
      sensor_addr  <= '0;
      sensor_wdata <= '0;
    end else begin
      sensor_wr <= sens_req;
      if (sens_req) begin
        sensor_addr  <= bus_addr;
        sensor_wdata <= bus_wdata;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      standby     <= 1'b0;
      dark_offset <= 1'b0;
      trig_q      <= 1'b0;
    end else if (ctrl_wr) begin
      standby     <= bus_wdata[STBY_BIT];
      dark_offset <= bus_wdata[DARK_BIT];
      trig_q      <= bus_wdata[TRIG_BIT];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trig_seen <= 1'b0;
    else        trig_seen <= trig_q;

  assign trig_pulse = trig_q ^ trig_seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cal_pend <= 1'b0;
    else        cal_pend <= (cal_pend & ~frame_gap) | cal_req;

  assign cal_start = cal_pend & frame_gap;
endmodule

// File: rtl/sensor_reg_bank_chk.sv
module sensor_reg_bank_chk #(
  parameter int DATA_W      = 8,
  parameter int OFFS_W      = 7,
  parameter int BANK_W      = 3,
  parameter int SENSOR_BANK = 0,
  parameter logic [OFFS_W-1:0] CTRL_OFFS = 'h70,
  parameter logic [OFFS_W-1:0] BANK_OFFS = 'h71,
  parameter int CAL_BIT     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_reg,
  input logic [OFFS_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              frame_gap,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sensor_wr,
  input logic              standby,
  input logic              trig_pulse,
  input logic              cal_start,
  input logic [BANK_W-1:0] bank_q
);
  wire ctrl_wr = bus_wr && bus_reg && bus_addr == CTRL_OFFS;
  wire cal_wr  = ctrl_wr && bus_wdata[CAL_BIT];
  wire bank_rd = bus_rd && bus_reg && bus_addr == BANK_OFFS;

  a_r8_cal_needs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> frame_gap);

  a_r8_cal_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start && !cal_wr |=> !cal_start);

  a_r5_sensor_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    sensor_wr |-> $past(bank_q) == BANK_W'(SENSOR_BANK));

  a_r4_bank_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd |=> bus_rdata[DATA_W-1:BANK_W] == '0);

  a_r6_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(standby));

  a_r11_trig_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse && !ctrl_wr |=> !trig_pulse);
endmodule

bind sensor_reg_bank sensor_reg_bank_chk #(
  .DATA_W(DATA_W), .OFFS_W(OFFS_W), .BANK_W(BANK_W), .SENSOR_BANK(SENSOR_BANK),
  .CTRL_OFFS(CTRL_OFFS), .BANK_OFFS(BANK_OFFS), .CAL_BIT(CAL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_reg(bus_reg),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .frame_gap(frame_gap),
  .bus_rdata(bus_rdata), .sensor_wr(sensor_wr), .standby(standby),
  .trig_pulse(trig_pulse), .cal_start(cal_start), .bank_q(bank_q)
);

// File: tb/sensor_reg_bank_bench.sv
`timescale 1ns/1ps
module sensor_reg_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_reg = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       frame_gap = 1'b0;
  logic [7:0] bus_rdata;
  logic       sensor_wr;
  logic [6:0] sensor_addr;
  logic [7:0] sensor_wdata;
  logic       standby, dark_offset, trig_pulse, cal_start;

  int checks = 0;
  int errors = 0;

  localparam logic [6:0] CTRL = 7'h70;
  localparam logic [6:0] BANK = 7'h71;

  always #2.5 clk = ~clk;

  sensor_reg_bank u_sensor_reg_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_reg(bus_reg),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .frame_gap(frame_gap),
    .bus_rdata(bus_rdata), .sensor_wr(sensor_wr), .sensor_addr(sensor_addr),
    .sensor_wdata(sensor_wdata), .standby(standby), .dark_offset(dark_offset),
    .trig_pulse(trig_pulse), .cal_start(cal_start)
  );

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_q <= bus_rd;

  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic rg, input logic [6:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_reg = rg; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic rg, input logic [6:0] a, input logic [7:0] e, input string tag);
    bus_rd = 1'b1; bus_reg = rg; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R12 standby", standby, 0);
    chk("R12 dark_offset", dark_offset, 0);
    chk("R12 sensor_wr", sensor_wr, 0);
    chk("R12 trig_pulse", trig_pulse, 0);
    chk("R12 cal_start", cal_start, 0);
    rd(1, BANK, 8'h00, "R12 bank after reset");
    frame_gap = 1'b1; #1;
    chk("R12 no pending cal", cal_start, 0);
    frame_gap = 1'b0;
    idle(1);

    wr(1, 7'h10, 8'h77);
    chk("R5 sensor_wr bank0", sensor_wr, 1);
    chk("R5 sensor_addr", sensor_addr, 7'h10);
    chk("R5 sensor_wdata", sensor_wdata, 8'h77);
    idle(1);
    chk("R5 sensor_wr one cycle", sensor_wr, 0);
    rd(1, 7'h10, 8'h77, "R3 register shadow readback");

    wr(1, BANK, 8'hFA);
    chk("R5 bank write not forwarded", sensor_wr, 0);
    rd(1, BANK, 8'h02, "R4 upper bank bits ignored");
    wr(0, 7'h05, 8'hA5);
    wr(1, BANK, 8'h03);
    wr(0, 7'h05, 8'h3C);
    wr(1, 7'h22, 8'h99);
    chk("R5 no sensor_wr in bank3", sensor_wr, 0);
    rd(0, 7'h05, 8'h3C, "R1 bank3 data");
    wr(1, BANK, 8'h02);
    rd(0, 7'h05, 8'hA5, "R1 bank2 data");
    wr(1, BANK, 8'h06);
    rd(0, 7'h10, 8'h77, "R2 shadow in bank6");
    rd(0, 7'h22, 8'h99, "R2 shadow written from bank3");
    rd(0, BANK, 8'h06, "R2 bank register shadowed");
    rd(1, 7'h22, 8'h99, "R3 register read in bank6");
    wr(1, BANK, 8'h00);
    idle(1);

    wr(1, CTRL, 8'h01);
    chk("R6 standby set", standby, 1);
    chk("R6 dark_offset clear", dark_offset, 0);
    chk("R6 ctrl not forwarded", sensor_wr, 0);
    wr(0, 7'h01, 8'hFF);
    chk("R6 standby held", standby, 1);
    wr(1, CTRL, 8'h02);
    chk("R6 standby cleared", standby, 0);
    chk("R6 dark_offset set", dark_offset, 1);
    rd(1, CTRL, 8'h02, "R3 ctrl shadow readback");

    wr(1, CTRL, 8'h0A);
    chk("R11 toggle pulse", trig_pulse, 1);
    idle(1);
    chk("R11 pulse one cycle", trig_pulse, 0);
    wr(1, CTRL, 8'h0A);
    chk("R11 same value no pulse", trig_pulse, 0);
    wr(1, CTRL, 8'h02);
    chk("R11 toggle back pulse", trig_pulse, 1);
    wr(1, CTRL, 8'h0A);
    chk("R11 back-to-back toggle pulse", trig_pulse, 1);
    idle(1);
    chk("R11 pulse ends", trig_pulse, 0);

    wr(1, CTRL, 8'h0A);
    frame_gap = 1'b1; #1;
    chk("R7 zero write sets nothing", cal_start, 0);
    frame_gap = 1'b0;
    idle(1);
    wr(1, CTRL, 8'h0E);
    idle(3);
    chk("R8 waits for gap", cal_start, 0);
    wr(1, CTRL, 8'h0A);
    wr(1, CTRL, 8'h0E);
    frame_gap = 1'b1; #1;
    chk("R7 pending survives zero write", cal_start, 1);
    @(negedge clk); #1;
    chk("R9 merged requests single start", cal_start, 0);
    frame_gap = 1'b0;
    idle(1);

    wr(1, CTRL, 8'h0E);
    frame_gap = 1'b1;
    bus_wr = 1'b1; bus_reg = 1'b1; bus_addr = CTRL; bus_wdata = 8'h0E;
    #1;
    chk("R10 issue cycle", cal_start, 1);
    @(negedge clk);
    bus_wr = 1'b0;
    frame_gap = 1'b0; #1;
    chk("R10 no start outside gap", cal_start, 0);
    idle(2);
    frame_gap = 1'b1; #1;
    chk("R10 retained request issued", cal_start, 1);
    @(negedge clk); #1;
    chk("R8 pending cleared after issue", cal_start, 0);
    frame_gap = 1'b0;
    idle(3);
    chk("scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule